// File: doc/BRIEF.md
# Platform System Control Register File

This block is the byte-wide register file that a single-processor board uses for system control. A host drives a synchronous strobe interface with a 16-bit I/O port address and an 8-bit data path. The block answers one stand-alone port at 0x092 and a window from 0x800 to 0x851. A few of these ports hold live control bits, and each bit drives a dedicated output. Those outputs are a soft-reset request, a little-endian mode flag, a drive-activity lamp, a four-bit cache-control field and a contiguous I/O map flag. Other ports return fixed bytes that describe the board: its processor configuration, its feature and status, the equipment fitted, its extended features, its keylock and its second-level cache status. Two ports have a side effect only. A write to either one sends a single-cycle lock-toggle pulse to an attached non-volatile memory.

Every read is registered. `io_rdata` is loaded at the clock edge that samples `io_rd` and holds its value until the next read. A read of any port that the block does not decode returns 0xFF. A write to such a port changes nothing. The reset input is asynchronous and active low. The block releases it synchronously through a two-flop synchronizer. All writable state clears to zero on reset.

Top module: `sysctl_regblk`

## Requirements
- R1: While reset is asserted, and directly after it, every control output, both lock pulses and `io_rdata` are 0.
- R2: A write to port 0x092 loads `reset_req` from data bit 0 and `le_mode` from data bit 1. A read of 0x092 returns `le_mode` in bit 1, with every other bit 0.
- R3: Port 0x800 reads 0xEF, port 0x802 reads 0xAD and port 0x803 reads 0xE0. Writes to these three ports change no output and no later read value.
- R4: Port 0x80C reads 0x3C, port 0x810 reads 0x39, port 0x818 reads 0x00 and port 0x823 reads 0x03.
- R5: Data bit 0 of a write to port 0x808 sets or clears `lamp_on`. No other access changes `lamp_on`.
- R6: Any write to port 0x810 raises `nv_lock1_pls` for exactly the one cycle after the write edge, whatever the data. A write to port 0x812 does the same on `nv_lock2_pls`. The two pulses are never high together.
- R7: A write to port 0x81C stores data bits 3:0 on `cache_ctl`. A read of 0x81C returns them in bits 3:0, with bits 7:4 as 0.
- R8: A write to port 0x850 latches data bit 0 onto `io_map_contig`. A read of 0x850 returns that bit in bit 0, with every other bit 0.
- R9: A read of any undecoded port returns 0xFF. This covers 0x808, 0x812 and 0x814, and addresses outside the window. A write to an undecoded port has no effect.
- R10: `io_rdata` takes its new value at the clock edge that samples `io_rd`. It holds its value while `io_rd` is low.
- R11: When a read and a write to the same port fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one access per cycle high |
| io_rd | input | 1 | Read strobe, one access per cycle high |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| reset_req | output | 1 | Soft-reset request |
| le_mode | output | 1 | Little-endian mode flag |
| lamp_on | output | 1 | Drive-activity lamp |
| cache_ctl | output | 4 | Cache-control bits |
| io_map_contig | output | 1 | Contiguous I/O map flag |
| nv_lock1_pls | output | 1 | Lock-toggle pulse, bank 1 |
| nv_lock2_pls | output | 1 | Lock-toggle pulse, bank 2 |

## Verification
Each control register drives its own output port. A corrupted bit therefore shows at the ports on the cycle after the write that caused it. The same bit shows again in `io_rdata` one cycle after the next read of that port. A fault in the decode shows up in one of two ways. It can make the wrong output move after a write to a neighbouring port. It can also turn a fixed byte into 0xFF, or 0xFF into some other value, on the first read that follows. A fault in the pulse logic shows as a pulse that is missing, doubled or stretched, in the cycle right after the write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned CACHE_W = 4;

  // Port addresses: behaviour depends on them, so they are fixed here.
  localparam logic [ADDR_W-1:0] PA_MODE    = 16'h0092;
  localparam logic [ADDR_W-1:0] PA_CPUCFG  = 16'h0800;
  localparam logic [ADDR_W-1:0] PA_FEAT    = 16'h0802;
  localparam logic [ADDR_W-1:0] PA_STAT    = 16'h0803;
  localparam logic [ADDR_W-1:0] PA_LAMP    = 16'h0808;
  localparam logic [ADDR_W-1:0] PA_EQUIP   = 16'h080C;
  localparam logic [ADDR_W-1:0] PA_LOCK1   = 16'h0810;
  localparam logic [ADDR_W-1:0] PA_LOCK2   = 16'h0812;
  localparam logic [ADDR_W-1:0] PA_KEYLOCK = 16'h0818;
  localparam logic [ADDR_W-1:0] PA_CACHE   = 16'h081C;
  localparam logic [ADDR_W-1:0] PA_L2STAT  = 16'h0823;
  localparam logic [ADDR_W-1:0] PA_MAPTYPE = 16'h0850;

  // Fixed identity bytes
  localparam logic [DATA_W-1:0] ID_CPUCFG  = 8'hEF;
  localparam logic [DATA_W-1:0] ID_FEAT    = 8'hAD;
  localparam logic [DATA_W-1:0] ID_STAT    = 8'hE0;
  localparam logic [DATA_W-1:0] ID_EQUIP   = 8'h3C;
  localparam logic [DATA_W-1:0] ID_EXTFEAT = 8'h39;
  localparam logic [DATA_W-1:0] ID_KEYLOCK = 8'h00;
  localparam logic [DATA_W-1:0] ID_L2STAT  = 8'h03;
  localparam logic [DATA_W-1:0] RD_DEFAULT = 8'hFF;

  // One bit per decoded port; at most one is set.
  typedef struct packed {
    logic mode;
    logic cpucfg;
    logic feat;
    logic stat;
    logic lamp;
    logic equip;
    logic lock1;
    logic lock2;
    logic keylock;
    logic cache;
    logic l2stat;
    logic maptype;
  } port_sel_t;

  // Live control state
  typedef struct packed {
    logic               rst_req;
    logic               le;
    logic               lamp;
    logic [CACHE_W-1:0] cache;
    logic               contig;
  } ctl_state_t;

endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output port_sel_t         sel
);

  always_comb begin
    sel         = '0;
    sel.mode    = (addr == PA_MODE);
    sel.cpucfg  = (addr == PA_CPUCFG);
    sel.feat    = (addr == PA_FEAT);
    sel.stat    = (addr == PA_STAT);
    sel.lamp    = (addr == PA_LAMP);
    sel.equip   = (addr == PA_EQUIP);
    sel.lock1   = (addr == PA_LOCK1);
    sel.lock2   = (addr == PA_LOCK2);
    sel.keylock = (addr == PA_KEYLOCK);
    sel.cache   = (addr == PA_CACHE);
    sel.l2stat  = (addr == PA_L2STAT);
    sel.maptype = (addr == PA_MAPTYPE);
  end

endmodule

// File: rtl/sysctl_ctrl_regs.sv
module sysctl_ctrl_regs
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  port_sel_t         sel,
  input  logic [DATA_W-1:0] wdata,
  output ctl_state_t        state,
  output logic              lock1_pls,
  output logic              lock2_pls
);

  ctl_state_t state_q, state_d;
  logic       mode_en, lamp_en, cache_en, map_en;
  logic       lock1_q, lock1_d, lock2_q, lock2_d;

  // Clock enables, one per register
  assign mode_en  = wr_en & sel.mode;
  assign lamp_en  = wr_en & sel.lamp;
  assign cache_en = wr_en & sel.cache;
  assign map_en   = wr_en & sel.maptype;

  // Next state
  always_comb begin
    state_d         = state_q;
    state_d.rst_req = wdata[0];
    state_d.le      = wdata[1];
    state_d.lamp    = wdata[0];
    state_d.cache   = wdata[CACHE_W-1:0];
    state_d.contig  = wdata[0];
    lock1_d         = wr_en & sel.lock1;
    lock2_d         = wr_en & sel.lock2;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
      lock1_q <= 1'b0;
      lock2_q <= 1'b0;
    end else begin
      if (mode_en) begin
        state_q.rst_req <= state_d.rst_req;
        state_q.le      <= state_d.le;
      end
      if (lamp_en) begin
        state_q.lamp <= state_d.lamp;
      end
      if (cache_en) begin
        state_q.cache <= state_d.cache;
      end
      if (map_en) begin
        state_q.contig <= state_d.contig;
      end
      lock1_q <= lock1_d;
      lock2_q <= lock2_d;
    end
  end

  assign state     = state_q;
  assign lock1_pls = lock1_q;
  assign lock2_pls = lock2_q;

  AST_ENDIAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel.mode) |=> (state_q.le == $past(wdata[1]) && state_q.rst_req == $past(wdata[0]))); // R2
  AST_LAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel.lamp) |=> $stable(state_q.lamp)); // R5
  AST_LOCK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock1_q && lock2_q)); // R6
  AST_LOCK1_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock1_q) |-> $past(wr_en)); // R6
  AST_CACHE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel.cache) |=> $stable(state_q.cache)); // R7
  AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && sel.maptype) |=> $stable(state_q.contig)); // R8

endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  port_sel_t         sel,
  input  ctl_state_t        state,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] rdata_q, rdata_d;

  // Next read value; the lock ports are write-only except 0x810,
  // which reads as the extended feature byte.
  always_comb begin
    rdata_d = RD_DEFAULT;
    unique case (1'b1)
      sel.mode:    rdata_d = {{(DATA_W-2){1'b0}}, state.le, 1'b0};
      sel.cpucfg:  rdata_d = ID_CPUCFG;
      sel.feat:    rdata_d = ID_FEAT;
      sel.stat:    rdata_d = ID_STAT;
      sel.equip:   rdata_d = ID_EQUIP;
      sel.lock1:   rdata_d = ID_EXTFEAT;
      sel.keylock: rdata_d = ID_KEYLOCK;
      sel.cache:   rdata_d = {{(DATA_W-CACHE_W){1'b0}}, state.cache};
      sel.l2stat:  rdata_d = ID_L2STAT;
      sel.maptype: rdata_d = {{(DATA_W-1){1'b0}}, state.contig};
      default:     rdata_d = RD_DEFAULT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata_q)); // R10
  AST_UNDEC_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == '0) |=> rdata_q == RD_DEFAULT); // R9
  AST_MODE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel.mode) |=> rdata_q == {6'b0, $past(state.le), 1'b0}); // R2

endmodule

// File: rtl/sysctl_regblk.sv
module sysctl_regblk
  import sysctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [DATA_W-1:0]  io_wdata,
  output logic [DATA_W-1:0]  io_rdata,
  output logic               reset_req,
  output logic               le_mode,
  output logic               lamp_on,
  output logic [CACHE_W-1:0] cache_ctl,
  output logic               io_map_contig,
  output logic               nv_lock1_pls,
  output logic               nv_lock2_pls
);

  logic       rst_n_int;
  port_sel_t  sel;
  ctl_state_t state;

  sysctl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  sysctl_decode u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  sysctl_ctrl_regs u_ctl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_en     (io_wr),
    .sel       (sel),
    .wdata     (io_wdata),
    .state     (state),
    .lock1_pls (nv_lock1_pls),
    .lock2_pls (nv_lock2_pls)
  );

  sysctl_rdmux u_rd (
    .clk   (clk),
    .rst_n (rst_n_int),
    .rd_en (io_rd),
    .sel   (sel),
    .state (state),
    .rdata (io_rdata)
  );

  assign reset_req     = state.rst_req;
  assign le_mode       = state.le;
  assign lamp_on       = state.lamp;
  assign cache_ctl     = state.cache;
  assign io_map_contig = state.contig;

  AST_ID_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_int)
    (io_wr && (io_addr == PA_CPUCFG || io_addr == PA_FEAT || io_addr == PA_STAT))
    |=> ($stable(reset_req) && $stable(le_mode) && $stable(lamp_on)
         && $stable(cache_ctl) && $stable(io_map_contig))); // R3
  AST_CACHE_READ: assert property (@(posedge clk) disable iff (!rst_n_int)
    (io_rd && io_addr == PA_CACHE) |=> io_rdata == {4'b0, $past(cache_ctl)}); // R11

endmodule

// File: tb/test_sysctl_regblk.sv
module test_sysctl_regblk;

  logic        clk;
  logic        rst_n;
  logic [15:0] io_addr;
  logic        io_wr;
  logic        io_rd;
  logic [7:0]  io_wdata;
  logic [7:0]  io_rdata;
  logic        reset_req, le_mode, lamp_on, io_map_contig;
  logic [3:0]  cache_ctl;
  logic        nv_lock1_pls, nv_lock2_pls;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  sysctl_regblk i_sysctl_regblk (
    .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wr (io_wr),
    .io_rd (io_rd), .io_wdata (io_wdata), .io_rdata (io_rdata),
    .reset_req (reset_req), .le_mode (le_mode), .lamp_on (lamp_on),
    .cache_ctl (cache_ctl), .io_map_contig (io_map_contig),
    .nv_lock1_pls (nv_lock1_pls), .nv_lock2_pls (nv_lock2_pls)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Row layout: {is_write, addr[15:0], wdata[7:0], expected read[7:0], req[3:0]}
  localparam int NVEC = 22;
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, 16'h0800, 8'h00, 8'hEF, 4'd3},   // R3
    {1'b0, 16'h0802, 8'h00, 8'hAD, 4'd3},   // R3
    {1'b0, 16'h0803, 8'h00, 8'hE0, 4'd3},   // R3
    {1'b1, 16'h0800, 8'h00, 8'h00, 4'd3},   // R3 write ignored
    {1'b0, 16'h0800, 8'h00, 8'hEF, 4'd3},   // R3
    {1'b0, 16'h080C, 8'h00, 8'h3C, 4'd4},   // R4
    {1'b0, 16'h0810, 8'h00, 8'h39, 4'd4},   // R4
    {1'b0, 16'h0818, 8'h00, 8'h00, 4'd4},   // R4
    {1'b0, 16'h0823, 8'h00, 8'h03, 4'd4},   // R4
    {1'b0, 16'h0814, 8'h00, 8'hFF, 4'd9},   // R9
    {1'b0, 16'h0812, 8'h00, 8'hFF, 4'd9},   // R9
    {1'b0, 16'h0808, 8'h00, 8'hFF, 4'd9},   // R9
    {1'b0, 16'h0851, 8'h00, 8'hFF, 4'd9},   // R9
    {1'b0, 16'h0000, 8'h00, 8'hFF, 4'd9},   // R9
    {1'b1, 16'h0092, 8'h03, 8'h00, 4'd2},   // R2
    {1'b0, 16'h0092, 8'h00, 8'h02, 4'd2},   // R2
    {1'b1, 16'h081C, 8'hA5, 8'h00, 4'd7},   // R7
    {1'b0, 16'h081C, 8'h00, 8'h05, 4'd7},   // R7
    {1'b1, 16'h0850, 8'hFF, 8'h00, 4'd8},   // R8
    {1'b0, 16'h0850, 8'h00, 8'h01, 4'd8},   // R8
    {1'b1, 16'h0092, 8'hFC, 8'h00, 4'd2},   // R2
    {1'b0, 16'h0092, 8'h00, 8'h00, 4'd2}    // R2
  };

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  function automatic logic [7:0] outs();
    return {reset_req, le_mode, lamp_on, cache_ctl, io_map_contig};
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] snap;
    rst_n = 1'b0; io_addr = '0; io_wr = 1'b0; io_rd = 1'b0; io_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1", "outputs in reset", outs(), 8'h00);
    check("R1", "pulses in reset", {6'b0, nv_lock1_pls, nv_lock2_pls}, 8'h00);
    check("R1", "rdata in reset", io_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "outputs after reset", outs(), 8'h00);

    // Vector table walk
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][36]) begin
        do_wr(VEC[i][35:20], VEC[i][19:12]);
      end else begin
        do_rd(VEC[i][35:20]);
        check($sformatf("R%0d", VEC[i][3:0]), $sformatf("read %03h", VEC[i][35:20]),
              io_rdata, VEC[i][11:4]);
      end
    end

    // R2: bit 0 alone sets reset request, bit 1 clear
    do_wr(16'h0092, 8'h01);
    check("R2", "reset_req/le_mode", {6'b0, reset_req, le_mode}, 8'h02);
    do_wr(16'h0092, 8'h02);
    check("R2", "reset_req/le_mode", {6'b0, reset_req, le_mode}, 8'h01);

    // R5: lamp
    do_wr(16'h0808, 8'hFE);
    check("R5", "lamp from even data", {7'b0, lamp_on}, 8'h00);
    do_wr(16'h0808, 8'h01);
    check("R5", "lamp set", {7'b0, lamp_on}, 8'h01);
    do_rd(16'h0808);
    check("R5", "lamp held over read", {7'b0, lamp_on}, 8'h01);

    // R6: lock pulses, one cycle each, data irrelevant
    do_wr(16'h0810, 8'h00);
    check("R6", "lock1 pulse", {6'b0, nv_lock1_pls, nv_lock2_pls}, 8'h02);
    @(negedge clk);
    check("R6", "lock1 pulse ends", {6'b0, nv_lock1_pls, nv_lock2_pls}, 8'h00);
    do_wr(16'h0812, 8'h5A);
    check("R6", "lock2 pulse", {6'b0, nv_lock1_pls, nv_lock2_pls}, 8'h01);
    @(negedge clk);
    check("R6", "lock2 pulse ends", {6'b0, nv_lock1_pls, nv_lock2_pls}, 8'h00);

    // R7 / R8 outputs
    do_wr(16'h081C, 8'hFA);
    check("R7", "cache_ctl", {4'b0, cache_ctl}, 8'h0A);
    do_wr(16'h0850, 8'h00);
    check("R8", "io_map_contig clear", {7'b0, io_map_contig}, 8'h00);
    do_wr(16'h0850, 8'h01);
    check("R8", "io_map_contig set", {7'b0, io_map_contig}, 8'h01);

    // R9: undecoded writes have no effect; R3: id writes too
    snap = outs();
    do_wr(16'h0814, 8'hFF);
    check("R9", "outputs after 0x814 write", outs(), snap);
    do_wr(16'h081D, 8'h00);
    check("R9", "outputs after 0x81D write", outs(), snap);
    do_wr(16'h0093, 8'h00);
    check("R9", "outputs after 0x093 write", outs(), snap);
    do_wr(16'h0803, 8'h00);
    check("R3", "outputs after 0x803 write", outs(), snap);
    do_rd(16'h081C);
    check("R9", "cache after undecoded writes", io_rdata, 8'h0A);

    // R10: latency and hold
    @(negedge clk);
    io_addr = 16'h0800; io_rd = 1'b1;
    #2;
    check("R10", "rdata before edge", io_rdata, 8'h0A);
    @(negedge clk);
    io_rd = 1'b0;
    check("R10", "rdata after edge", io_rdata, 8'hEF);
    io_addr = 16'h0823;
    repeat (2) @(negedge clk);
    check("R10", "rdata held", io_rdata, 8'hEF);

    // R11: read and write same cycle return old value
    @(negedge clk);
    io_addr = 16'h081C; io_wdata = 8'h03; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check("R11", "simultaneous read", io_rdata, 8'h0A);
    do_rd(16'h081C);
    check("R11", "read after write", io_rdata, 8'h03);

    // R1: mid-run reset clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "outputs after mid-run reset", outs(), 8'h00);
    check("R1", "rdata after mid-run reset", io_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule